// File: doc/BRIEF.md
# Programmable Asynchronous Memory Read Sequencer

This block runs one asynchronous read from an external parallel memory or peripheral, with time counted in cycles of the interface clock. A request with an address starts an access. From then on a cycle counter steps from 0. The chip-select, address-valid and output-enable strobes are each active low. Each one is low over a window whose opening and closing counts come from its own timing fields. A separate count picks the cycle whose end samples the read data. Another count sets the last cycle of the access.

A mode input selects an address/data-multiplexed device. In that mode the shared data bus carries the low address bits until output enable opens, and is then handed to the device. The direction output turns inbound in the same cycle that output enable asserts. When no transfer is inbound, the block drives the bus itself. Outside the address phase it drives the last value read, so the bus never floats between accesses. All timing fields are sampled when a request is accepted, so each access runs on its own settings.

Top module: `rdSeqTop`

## Requirements
- R1: A request (`reqValid` high at a clock edge) is accepted only while `reqReady` is high. `reqReady` is high exactly when no access is in progress. The cycle after the accepting edge is access cycle 0, and a request raised during an access is ignored and never queued.
- R2: `memCsN` is low in access cycle n exactly when `cfgCsOn` <= n < `cfgCsOff`.
- R3: `memAdvN` is low in access cycle n exactly when `cfgAdvOn` <= n < `cfgAdvOff`.
- R4: `memOeN` is low in access cycle n exactly when `cfgOeOn` <= n < `cfgOeOff`.
- R5: `memDirIn` is 1 (inbound) from access cycle `cfgOeOn` to the end of the access and 0 otherwise, so it rises in the cycle that `memOeN` falls. `busDrive` is always the inverse of `memDirIn`.
- R6: The capture index is c = min(`cfgAccess`, L), with L as in R7. `busIn` is sampled at the clock edge that ends access cycle c. In the next cycle `rdData` shows that value and `rdValid` is high for exactly that one cycle.
- R7: The access covers cycles 0 to L, where L = `cfgCycle` - 1, or L = 0 when `cfgCycle` is 0. In the cycle after cycle L, all three strobes are high and `reqReady` is high.
- R8: `memAddr` holds the accepted address from access cycle 0 on. With `cfgMux` = 1, `busOut` carries the low `DATA_W` address bits in access cycles before `cfgOeOn`.
- R9: Whenever `busDrive` is 1 and the address is not on the bus, `busOut` equals the most recently captured read value, which is 0 after reset.
- R10: Timing fields and `cfgMux` are sampled at the accepting edge. Changing them during an access has no effect on that access.
- R11: During and right after reset, all strobes are high, `reqReady` = 1, `rdValid` = 0, `memDirIn` = 0, `busDrive` = 1 and `busOut` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request |
| reqAddr | input | ADDR_W | Read address |
| reqReady | output | 1 | Idle, a request will be accepted |
| rdData | output | DATA_W | Last captured read value |
| rdValid | output | 1 | One-cycle pulse, new read value on rdData |
| cfgCsOn | input | 4 | Chip-select assert count |
| cfgCsOff | input | 5 | Chip-select release count |
| cfgAdvOn | input | 4 | Address-valid assert count |
| cfgAdvOff | input | 5 | Address-valid release count |
| cfgOeOn | input | 4 | Output-enable assert count |
| cfgOeOff | input | 5 | Output-enable release count |
| cfgAccess | input | 5 | Data capture count |
| cfgCycle | input | 5 | Access length in cycles |
| cfgMux | input | 1 | 1 selects an address/data-multiplexed device |
| memCsN | output | 1 | Chip select, active low |
| memAdvN | output | 1 | Address valid, active low |
| memOeN | output | 1 | Output enable, active low |
| memDirIn | output | 1 | Bus direction, 1 = inbound |
| memAddr | output | ADDR_W | Address pins |
| busOut | output | DATA_W | Value driven on the data bus |
| busDrive | output | 1 | Data bus driven by this block |
| busIn | input | DATA_W | Value read from the data bus |

## Verification
Data capture and the end of the access fall in the same cycle when the capture count is at or beyond the last cycle. One table entry sets the capture count to 20 with a cycle length of 5, and another sets the cycle length to 0. A changing pattern is placed on `busIn` in every cycle. The bench then requires `rdValid` in the first idle cycle, together with all strobes released, `reqReady` high and the bus driving the value sampled in the final cycle. The second collision is output enable opening in the same cycle that the bus turns inbound and releases the multiplexed address; it is judged cycle by cycle on `memOeN`, `memDirIn`, `busDrive` and `busOut`.

// File: rtl/rdSeqPkg.sv
package rdSeqPkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 5;
  localparam int CNT_W = OFF_W;
  localparam int N_STROBE = 3;

  // timing captured at request acceptance
  typedef struct packed {
    logic [ON_W-1:0]  csOn;
    logic [OFF_W-1:0] csOff;
    logic [ON_W-1:0]  advOn;
    logic [OFF_W-1:0] advOff;
    logic [ON_W-1:0]  oeOn;
    logic [OFF_W-1:0] oeOff;
    logic [CNT_W-1:0] capIdx;
    logic [CNT_W-1:0] lastIdx;
    logic             mux;
  } rdTiming_t;

  // control to datapath
  typedef struct packed {
    logic accept;
    logic drvAddr;
    logic dirIn;
    logic capture;
  } rdStrobe_t;

  function automatic logic inWindow(input logic [CNT_W-1:0] cnt,
                                    input logic [ON_W-1:0]  onAt,
                                    input logic [OFF_W-1:0] offAt);
    return (cnt >= CNT_W'(onAt)) && (cnt < offAt);
  endfunction
endpackage

// File: rtl/rdSeqCtrl.sv
module rdSeqCtrl
  import rdSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [ON_W-1:0]  cfgCsOn,
  input  logic [OFF_W-1:0] cfgCsOff,
  input  logic [ON_W-1:0]  cfgAdvOn,
  input  logic [OFF_W-1:0] cfgAdvOff,
  input  logic [ON_W-1:0]  cfgOeOn,
  input  logic [OFF_W-1:0] cfgOeOff,
  input  logic [CNT_W-1:0] cfgAccess,
  input  logic [CNT_W-1:0] cfgCycle,
  input  logic             cfgMux,
  output logic             reqReady,
  output logic             memCsN,
  output logic             memAdvN,
  output logic             memOeN,
  output rdStrobe_t        st
);
  logic             busy;
  logic [CNT_W-1:0] cnt;
  rdTiming_t        tim;
  rdTiming_t        timNext;
  logic             accept;
  logic             endNow;
  logic [ON_W-1:0]  onV  [N_STROBE];
  logic [OFF_W-1:0] offV [N_STROBE];
  logic [N_STROBE-1:0] winOn;

  // derive last cycle and clamped capture index once, at acceptance
  always_comb begin
    timNext.csOn    = cfgCsOn;
    timNext.csOff   = cfgCsOff;
    timNext.advOn   = cfgAdvOn;
    timNext.advOff  = cfgAdvOff;
    timNext.oeOn    = cfgOeOn;
    timNext.oeOff   = cfgOeOff;
    timNext.mux     = cfgMux;
    timNext.lastIdx = (cfgCycle == '0) ? '0 : cfgCycle - CNT_W'(1);
    timNext.capIdx  = (cfgAccess > timNext.lastIdx) ? timNext.lastIdx : cfgAccess;
  end

  assign accept = reqValid && !busy;
  assign endNow = busy && (cnt == tim.lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      tim  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
      tim  <= timNext;
    end else if (busy) begin
      if (endNow) busy <= 1'b0;
      else        cnt  <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    onV[0] = tim.csOn;  offV[0] = tim.csOff;
    onV[1] = tim.advOn; offV[1] = tim.advOff;
    onV[2] = tim.oeOn;  offV[2] = tim.oeOff;
  end

  for (genvar g = 0; g < N_STROBE; g++) begin : gWin
    assign winOn[g] = busy && inWindow(cnt, onV[g], offV[g]);
  end

  assign memCsN   = !winOn[0];
  assign memAdvN  = !winOn[1];
  assign memOeN   = !winOn[2];
  assign reqReady = !busy;

  always_comb begin
    st.accept  = accept;
    st.drvAddr = busy && tim.mux && (cnt < CNT_W'(tim.oeOn));
    st.dirIn   = busy && (cnt >= CNT_W'(tim.oeOn));
    st.capture = busy && (cnt == tim.capIdx);
  end

  // R1: every access starts from cycle 0
  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (cnt == '0));

  // R7: counter advances by one each cycle until the last one
  a_r7_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !endNow) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));

  // R7: all strobes released right after the final cycle
  a_r7_end_releases: assert property (@(posedge clk) disable iff (!rstN)
    endNow |=> (memCsN && memAdvN && memOeN && reqReady));

  // R10: captured timing frozen during the access
  a_r10_timing_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(tim));

  // R5: direction is inbound whenever output enable has just asserted
  a_r5_dir_with_oe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memOeN) |-> st.dirIn);
endmodule

// File: rtl/rdSeqDatapath.sv
module rdSeqDatapath
  import rdSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         st,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] keepReg;
  logic [DATA_W-1:0] addrOnBus;
  logic              validReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      keepReg  <= '0;
      validReg <= 1'b0;
    end else begin
      if (st.accept)  addrReg <= reqAddr;
      if (st.capture) keepReg <= busIn;
      validReg <= st.capture;
    end
  end

  if (ADDR_W >= DATA_W) begin : gAddrWide
    assign addrOnBus = addrReg[DATA_W-1:0];
  end else begin : gAddrNarrow
    assign addrOnBus = {{(DATA_W-ADDR_W){1'b0}}, addrReg};
  end

  assign memAddr  = addrReg;
  assign busDrive = !st.dirIn;
  assign busOut   = st.drvAddr ? addrOnBus : keepReg;
  assign rdData   = keepReg;
  assign rdValid  = validReg;

  // R6: a capture edge yields the sampled value with a valid pulse
  a_r6_capture_valid: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |=> (rdValid && rdData == $past(busIn)));

  // R9: kept bus value does not move without a capture or address phase
  a_r9_keep_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(st.capture) && !$past(st.drvAddr) && !st.drvAddr && busDrive)
      |-> $stable(busOut));
endmodule

// File: rtl/rdSeqTop.sv
module rdSeqTop
  import rdSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic [3:0]        cfgCsOn,
  input  logic [4:0]        cfgCsOff,
  input  logic [3:0]        cfgAdvOn,
  input  logic [4:0]        cfgAdvOff,
  input  logic [3:0]        cfgOeOn,
  input  logic [4:0]        cfgOeOff,
  input  logic [4:0]        cfgAccess,
  input  logic [4:0]        cfgCycle,
  input  logic              cfgMux,
  output logic              memCsN,
  output logic              memAdvN,
  output logic              memOeN,
  output logic              memDirIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  input  logic [DATA_W-1:0] busIn
);
  rdStrobe_t st;

  rdSeqCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .cfgCsOn(cfgCsOn), .cfgCsOff(cfgCsOff),
    .cfgAdvOn(cfgAdvOn), .cfgAdvOff(cfgAdvOff),
    .cfgOeOn(cfgOeOn), .cfgOeOff(cfgOeOff),
    .cfgAccess(cfgAccess), .cfgCycle(cfgCycle), .cfgMux(cfgMux),
    .reqReady(reqReady), .memCsN(memCsN), .memAdvN(memAdvN),
    .memOeN(memOeN), .st(st)
  );

  rdSeqDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .st(st), .reqAddr(reqAddr), .busIn(busIn),
    .memAddr(memAddr), .busOut(busOut), .busDrive(busDrive),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign memDirIn = st.dirIn;
endmodule

// File: tb/test_rdSeqTop.sv
module test_rdSeqTop;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NV = 6;

  // {csOn, csOff, advOn, advOff, oeOn, oeOff, access, cycle, mux}
  localparam logic [37:0] VECS [NV] = '{
    {4'd0, 5'd10, 4'd0, 5'd1,  4'd3, 5'd10, 5'd9,  5'd11, 1'b0},
    {4'd0, 5'd10, 4'd0, 5'd1,  4'd3, 5'd10, 5'd9,  5'd11, 1'b1},
    {4'd1, 5'd4,  4'd2, 5'd3,  4'd2, 5'd6,  5'd5,  5'd7,  1'b0},
    {4'd0, 5'd3,  4'd0, 5'd2,  4'd1, 5'd4,  5'd20, 5'd5,  1'b1},
    {4'd0, 5'd1,  4'd0, 5'd1,  4'd0, 5'd1,  5'd0,  5'd0,  1'b0},
    {4'd2, 5'd31, 4'd1, 5'd31, 4'd3, 5'd31, 5'd6,  5'd8,  1'b1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, reqValid, reqReady, rdValid, cfgMux;
  logic [AW-1:0] reqAddr, memAddr;
  logic [DW-1:0] rdData, busOut, busIn;
  logic [3:0] cfgCsOn, cfgAdvOn, cfgOeOn;
  logic [4:0] cfgCsOff, cfgAdvOff, cfgOeOff, cfgAccess, cfgCycle;
  logic memCsN, memAdvN, memOeN, memDirIn, busDrive;

  rdSeqTop #(.ADDR_W(AW), .DATA_W(DW)) i_rdSeqTop (.*);

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] keepModel = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic applyCfg(input logic [37:0] v);
    {cfgCsOn, cfgCsOff, cfgAdvOn, cfgAdvOff, cfgOeOn, cfgOeOff,
     cfgAccess, cfgCycle, cfgMux} = v;
  endtask

  // mode 0 plain, 1 config changed mid-access, 2 request raised while busy
  task automatic runAccess(input logic [37:0] v, input logic [AW-1:0] a,
                           input logic [DW-1:0] base, input int mode);
    int csOn, csOff, advOn, advOff, oeOn, oeOff, acc, cyc, lastIdx, capIdx;
    logic mux;
    logic [DW-1:0] newKeep, expBus;
    string tg;
    csOn = int'(v[37:34]); csOff = int'(v[33:29]);
    advOn = int'(v[28:25]); advOff = int'(v[24:20]);
    oeOn = int'(v[19:16]); oeOff = int'(v[15:11]);
    acc = int'(v[10:6]); cyc = int'(v[5:1]); mux = v[0];
    lastIdx = (cyc == 0) ? 0 : cyc - 1;
    capIdx = (acc > lastIdx) ? lastIdx : acc;
    newKeep = base ^ DW'(capIdx);
    tg = (mode == 1) ? "R10 " : "";
    @(negedge clk);
    applyCfg(v);
    reqAddr = a;
    reqValid = 1'b1;
    chk("R1 ready before request", 32'(reqReady), 32'd1);
    @(posedge clk);
    #1 reqValid = 1'b0;
    for (int n = 0; n <= lastIdx; n++) begin
      @(negedge clk);
      busIn = base ^ DW'(n);
      chk({tg, "R2 memCsN"},  32'(memCsN),  32'(!(n >= csOn && n < csOff)));
      chk({tg, "R3 memAdvN"}, 32'(memAdvN), 32'(!(n >= advOn && n < advOff)));
      chk({tg, "R4 memOeN"},  32'(memOeN),  32'(!(n >= oeOn && n < oeOff)));
      chk({tg, "R5 memDirIn"}, 32'(memDirIn), 32'(n >= oeOn));
      chk({tg, "R5 busDrive"}, 32'(busDrive), 32'(!(n >= oeOn)));
      chk("R1 busy not ready", 32'(reqReady), 32'd0);
      chk("R6 rdValid timing", 32'(rdValid), 32'(n == capIdx + 1));
      if (n == capIdx + 1) chk("R6 rdData value", 32'(rdData), 32'(newKeep));
      if (n == 0) chk("R8 memAddr", 32'(memAddr), 32'(a));
      if (n < oeOn) begin
        if (mux) expBus = a[DW-1:0];
        else expBus = (n > capIdx) ? newKeep : keepModel;
        chk({tg, mux ? "R8 address on bus" : "R9 kept value"}, 32'(busOut), 32'(expBus));
      end
      if (mode == 1 && n == 1) applyCfg('1);
      if (mode == 2 && n == 2) begin
        reqValid = 1'b1;
        reqAddr = a ^ '1;
      end
      if (mode == 2 && n == 3) begin
        chk("R1 address unchanged by busy request", 32'(memAddr), 32'(a));
        reqValid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R7 strobes released", 32'({memCsN, memAdvN, memOeN}), 32'b111);
    chk("R7 ready after end", 32'(reqReady), 32'd1);
    chk("R6 rdValid at end", 32'(rdValid), 32'(capIdx == lastIdx));
    chk("R6 rdData at end", 32'(rdData), 32'(newKeep));
    chk("R9 drive after read", 32'(busDrive), 32'd1);
    chk("R9 bus keeps read value", 32'(busOut), 32'(newKeep));
    keepModel = newKeep;
    if (mode == 2) begin
      @(negedge clk);
      chk("R1 busy request not queued", 32'(memCsN), 32'd1);
      chk("R1 still idle", 32'(reqReady), 32'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    reqValid = 1'b1;
    reqAddr = '0;
    busIn = '0;
    applyCfg(VECS[0]);
    repeat (3) @(negedge clk);
    chk("R11 strobes in reset", 32'({memCsN, memAdvN, memOeN}), 32'b111);
    chk("R11 ready in reset", 32'(reqReady), 32'd1);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 rdValid", 32'(rdValid), 32'd0);
    chk("R11 memDirIn", 32'(memDirIn), 32'd0);
    chk("R11 busDrive", 32'(busDrive), 32'd1);
    chk("R11 busOut", 32'(busOut), 32'd0);
    chk("R11 strobes idle", 32'({memCsN, memAdvN, memOeN}), 32'b111);

    for (int i = 0; i < NV; i++)
      runAccess(VECS[i], AW'(16'h1000 + i * 16'h0111), DW'(16'hA500 + i * 16), 0);

    runAccess(VECS[2], 16'h2468, 16'h5A00, 1);
    runAccess(VECS[0], 16'h1357, 16'h3C00, 2);

    summary();
    $finish;
  end
endmodule